// File: doc/BRIEF.md
# Command-Driven Multi-Lane Serial Word Engine

This block is a half-duplex serial master. Each time software writes a command word, it moves one word over the serial lines. A word is 1 to 128 bits long. Writes always use one lane. Reads use one, two or four lanes. The word to send is taken from four 32-bit data registers, and a received word is written back into them. A status register tells software when the engine is busy and when the last word has finished.

Words are grouped into frames. The first command of a frame latches a chip-select number and a frame length. That chip select then stays active across all the words of the frame. It drops when the last word of the frame has finished, or as soon as an invalidate command arrives.

Bit timing comes from outside. A one-cycle `sclk_tick` strobe moves one beat of 1, 2 or 4 bits, so clock division is not part of this block.

Top module: `sqw_engine`

## Requirements
- R1: After reset, status reads 0, every chip-select line sits at its inactive level (the inverse of its `cs_pol` bit), `io_oe` is 0 and all four data registers read 0.
- R2: The command word layout is: bits 29:28 chip select, bits 25:19 word length minus one, bits 18:16 operation, bits 11:0 frame length minus one. The operation codes are 1 single-lane read, 2 single-lane write, 3 dual-lane read, 7 quad-lane read and 4 invalidate. Any other code starts nothing.
- R3: The registers sit at these addresses: 0 command, 1 status, 4 to 7 data words 0 to 3. The four data words form a 128-bit value with word 3 the most significant. A write of N bits sends the low N bits of that value on `io_out[0]`, most significant bit first, one bit per tick.
- R4: A read samples `io_in[1]` on single lane, `io_in[1:0]` on dual lane and `io_in[3:0]` on quad lane, with the higher-numbered line carrying the more significant bit. The N received bits land in the low N bits of the 128-bit data value, and all higher bits are cleared.
- R5: BUSY rises in the cycle after an accepted command write. WC rises, and BUSY falls, on the tick that moves the last beat. An accepted command write clears WC.
- R6: The chip select becomes active at the first word of a frame and stays active between words. It goes inactive when the word that completes the frame length finishes.
- R7: An invalidate command ends the frame at once. It moves no data, and the next transfer command starts a new frame with its own chip select.
- R8: A command written while BUSY is high is ignored.
- R9: A data register write while BUSY is high is ignored.
- R10: The active level of each chip-select line is its `cs_pol` bit (1 means active high). At most one line is active at a time.
- R11: Status bit 0 is BUSY and status bit 1 is WC.
- R12: `io_oe` is 4'b0001 during a write transfer and 0 at all other times, including during reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from `reg_addr`) |
| cs_pol | input | NUM_CS | Active level per chip select |
| sclk_tick | input | 1 | Beat strobe from the clock divider |
| io_in | input | 4 | Serial lines, input side |
| io_out | output | 4 | Serial lines, output side |
| io_oe | output | 4 | Output enables for the serial lines |
| sck | output | 1 | One-cycle pulse following each moved beat |
| cs_o | output | NUM_CS | Chip-select lines |

## Verification
The bench targets several corner cases, and each has a distinct failure signature:

- **Frame boundary.** A design that counts frame length off by one releases chip select one word early or one word late.
- **Invalidate.** A design that forgets the latched frame keeps the old select active into the next frame.
- **Lane ordering.** The dual and quad reads use patterns in which a swapped lane order or a wrong single-read line produces a visibly different word.
- **128-bit word.** A full-length write catches a mistake in the data-word significance or in the MSB alignment.
- **Writes during BUSY.** Command and data writes are issued mid-word. A design that accepts them drops chip select, restarts the word, or corrupts the stored data.

// File: rtl/sqw_pkg.sv
// Shared constants and types for the serial word engine.
// Assumes a 32-bit register interface and at most four chip selects.
package sqw_pkg;
    localparam int DATA_W   = 32;
    localparam int DATA_N   = 4;
    localparam int WORD_MAX = DATA_W * DATA_N;
    localparam int WL_W     = $clog2(WORD_MAX);
    localparam int CNT_W    = WL_W + 1;
    localparam int FL_W     = 12;
    localparam int LANES    = 4;
    localparam int AD_W     = 3;

    localparam logic [2:0] OP_RD1 = 3'd1;
    localparam logic [2:0] OP_WR1 = 3'd2;
    localparam logic [2:0] OP_RD2 = 3'd3;
    localparam logic [2:0] OP_INV = 3'd4;
    localparam logic [2:0] OP_RD4 = 3'd7;

    localparam logic [AD_W-1:0] A_CMD  = 3'd0;
    localparam logic [AD_W-1:0] A_STAT = 3'd1;

    typedef enum logic [1:0] {LN_1, LN_2, LN_4} lane_e;

    typedef struct packed {
        logic [1:0]      cs;
        logic [WL_W-1:0] wl_m1;
        logic [2:0]      op;
        logic [FL_W-1:0] fl_m1;
    } cmd_t;
endpackage

// File: rtl/sqw_cmd_decode.sv
// Purely combinational decode of a raw command word into its fields
// and a classification: transfer, invalidate, or nothing.
// Assumes the fixed field layout of the command register.
module sqw_cmd_decode
    import sqw_pkg::*;
(
    input  logic [DATA_W-1:0] raw_i,
    output cmd_t              fld_o,
    output logic              xfer_o,
    output logic              inval_o,
    output logic              read_o,
    output lane_e             lanes_o
);
    // Field extraction
    always_comb begin
        fld_o.cs    = raw_i[29:28];
        fld_o.wl_m1 = raw_i[25:19];
        fld_o.op    = raw_i[18:16];
        fld_o.fl_m1 = raw_i[11:0];
    end

    // Operation classification
    always_comb begin
        xfer_o  = 1'b0;
        inval_o = 1'b0;
        read_o  = 1'b0;
        lanes_o = LN_1;
        case (raw_i[18:16])
            OP_RD1: begin xfer_o = 1'b1; read_o = 1'b1; end
            OP_WR1: xfer_o = 1'b1;
            OP_RD2: begin xfer_o = 1'b1; read_o = 1'b1; lanes_o = LN_2; end
            OP_RD4: begin xfer_o = 1'b1; read_o = 1'b1; lanes_o = LN_4; end
            OP_INV: inval_o = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/sqw_shifter.sv
// Shift datapath for one word. Writes present the MSB on line 0 and
// shift once per tick. Reads shift in 1, 2 or 4 bits per tick.
// Assumes the word length is a multiple of the lane count.
module sqw_shifter
    import sqw_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                read_i,
    input  lane_e               lanes_i,
    input  logic [WL_W-1:0]     wl_m1_i,
    input  logic [WORD_MAX-1:0] load_i,
    input  logic                tick_i,
    input  logic [LANES-1:0]    io_in_i,
    output logic                busy_o,
    output logic                rd_o,
    output logic                fin_o,
    output logic [WORD_MAX-1:0] word_nxt_o,
    output logic [LANES-1:0]    io_out_o,
    output logic [LANES-1:0]    io_oe_o,
    output logic                sck_o
);
    localparam logic [WL_W-1:0] TOP_IDX = WL_W'(WORD_MAX - 1);

    logic                busy_q, rd_q, sck_q;
    lane_e               lanes_q;
    logic [WORD_MAX-1:0] sr_q;
    logic [CNT_W-1:0]    left_q, step;

    // Bits moved per tick for the latched lane mode
    always_comb begin
        case (lanes_q)
            LN_2:    step = CNT_W'(2);
            LN_4:    step = CNT_W'(4);
            default: step = CNT_W'(1);
        endcase
    end

    // Next shift-register value for one beat
    always_comb begin
        if (!rd_q) word_nxt_o = {sr_q[WORD_MAX-2:0], 1'b0};
        else begin
            case (lanes_q)
                LN_2:    word_nxt_o = {sr_q[WORD_MAX-3:0], io_in_i[1:0]};
                LN_4:    word_nxt_o = {sr_q[WORD_MAX-5:0], io_in_i};
                default: word_nxt_o = {sr_q[WORD_MAX-2:0], io_in_i[1]};
            endcase
        end
    end

    assign fin_o = busy_q && tick_i && (left_q <= step);

    // Word state: load on start, shift on tick, stop at last beat
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            rd_q    <= 1'b0;
            lanes_q <= LN_1;
            sr_q    <= '0;
            left_q  <= '0;
            sck_q   <= 1'b0;
        end else begin
            sck_q <= busy_q && tick_i;
            if (start_i) begin
                busy_q  <= 1'b1;
                rd_q    <= read_i;
                lanes_q <= lanes_i;
                left_q  <= CNT_W'(wl_m1_i) + CNT_W'(1);
                sr_q    <= read_i ? '0 : (load_i << (TOP_IDX - wl_m1_i));
            end else if (busy_q && tick_i) begin
                sr_q   <= word_nxt_o;
                left_q <= left_q - step;
                if (left_q <= step) busy_q <= 1'b0;
            end
        end
    end

    assign busy_o   = busy_q;
    assign rd_o     = rd_q;
    assign sck_o    = sck_q;
    assign io_oe_o  = (busy_q && !rd_q) ? LANES'(1) : '0;
    assign io_out_o = {{(LANES-1){1'b0}}, busy_q && !rd_q && sr_q[WORD_MAX-1]};
endmodule

// File: rtl/sqw_frame.sv
// Frame tracking: latches the select and length at the first word,
// counts finished words, and drives the chip-select lines with
// per-line polarity. Assumes NUM_CS is at most four.
module sqw_frame
    import sqw_pkg::*;
#(
    parameter int NUM_CS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              inval_i,
    input  logic              fin_i,
    input  logic [1:0]        cs_sel_i,
    input  logic [FL_W-1:0]   fl_m1_i,
    input  logic [NUM_CS-1:0] cs_pol_i,
    output logic [NUM_CS-1:0] cs_o
);
    logic            in_frame_q;
    logic [1:0]      cur_cs_q;
    logic [FL_W-1:0] fl_m1_q, wcnt_q;

    // Frame open, word counting and close
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_frame_q <= 1'b0;
            cur_cs_q   <= '0;
            fl_m1_q    <= '0;
            wcnt_q     <= '0;
        end else if (inval_i) begin
            in_frame_q <= 1'b0;
            wcnt_q     <= '0;
        end else if (start_i && !in_frame_q) begin
            in_frame_q <= 1'b1;
            cur_cs_q   <= cs_sel_i;
            fl_m1_q    <= fl_m1_i;
            wcnt_q     <= '0;
        end else if (fin_i) begin
            if (wcnt_q == fl_m1_q) begin
                in_frame_q <= 1'b0;
                wcnt_q     <= '0;
            end else begin
                wcnt_q <= wcnt_q + FL_W'(1);
            end
        end
    end

    // One chip-select driver per line
    for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
        assign cs_o[i] = (in_frame_q && cur_cs_q == 2'(i)) ? cs_pol_i[i] : ~cs_pol_i[i];
    end
endmodule

// File: rtl/sqw_engine.sv
// Top level: register file, command acceptance and result capture.
// Commands and data writes are ignored while a word is in flight.
// Assumes sclk_tick is a one-cycle strobe from an external divider.
module sqw_engine
    import sqw_pkg::*;
#(
    parameter int NUM_CS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [NUM_CS-1:0] cs_pol,
    input  logic              sclk_tick,
    input  logic [3:0]        io_in,
    output logic [3:0]        io_out,
    output logic [3:0]        io_oe,
    output logic              sck,
    output logic [NUM_CS-1:0] cs_o
);
    logic [DATA_N-1:0][DATA_W-1:0] data_q;
    logic [DATA_W-1:0]             cmd_q;
    logic                          wc_q;
    logic                          busy, shf_rd, fin;
    logic [WORD_MAX-1:0]           word_nxt;
    cmd_t                          fld;
    logic                          is_xfer, is_inval, is_read;
    lane_e                         lanes;
    logic                          accept;

    assign accept = reg_we && (reg_addr == A_CMD) && !busy;

    sqw_cmd_decode u_dec (
        .raw_i(reg_wdata), .fld_o(fld), .xfer_o(is_xfer),
        .inval_o(is_inval), .read_o(is_read), .lanes_o(lanes)
    );

    sqw_shifter u_shf (
        .clk(clk), .rst_n(rst_n), .start_i(accept && is_xfer),
        .read_i(is_read), .lanes_i(lanes), .wl_m1_i(fld.wl_m1),
        .load_i(data_q), .tick_i(sclk_tick), .io_in_i(io_in),
        .busy_o(busy), .rd_o(shf_rd), .fin_o(fin), .word_nxt_o(word_nxt),
        .io_out_o(io_out), .io_oe_o(io_oe), .sck_o(sck)
    );

    sqw_frame #(.NUM_CS(NUM_CS)) u_frm (
        .clk(clk), .rst_n(rst_n), .start_i(accept && is_xfer),
        .inval_i(accept && is_inval), .fin_i(fin), .cs_sel_i(fld.cs),
        .fl_m1_i(fld.fl_m1), .cs_pol_i(cs_pol), .cs_o(cs_o)
    );

    // Register writes, word-complete flag and read-data capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            cmd_q  <= '0;
            wc_q   <= 1'b0;
        end else begin
            if (accept) begin
                cmd_q <= reg_wdata;
                wc_q  <= 1'b0;
            end
            if (fin) begin
                wc_q <= 1'b1;
                if (shf_rd) data_q <= word_nxt;
            end
            if (reg_we && reg_addr[2] && !busy) data_q[reg_addr[1:0]] <= reg_wdata;
        end
    end

    // Register read mux
    always_comb begin
        if (reg_addr[2])              reg_rdata = data_q[reg_addr[1:0]];
        else if (reg_addr == A_CMD)   reg_rdata = cmd_q;
        else if (reg_addr == A_STAT)  reg_rdata = {30'd0, wc_q, busy};
        else                          reg_rdata = '0;
    end
endmodule

// File: rtl/sqw_checker.sv
// Protocol checks on the engine, bound into every instance.
module sqw_checker #(
    parameter int NUM_CS = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sclk_tick,
    input logic [NUM_CS-1:0] cs_o,
    input logic [NUM_CS-1:0] cs_pol,
    input logic [3:0]        io_oe,
    input logic              busy,
    input logic              wc_q
);
    // R5: busy and word-complete are never both set
    a_r5_busy_wc_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && wc_q));
    // R5: word-complete only rises after a beat strobe
    a_r5_wc_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wc_q) |-> $past(sclk_tick));
    // R8: nothing but a beat can end a word in flight
    a_r8_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !sclk_tick |=> busy);
    // R6: chip selects do not move mid-word without a beat
    a_r6_cs_stable: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !sclk_tick |=> $stable(cs_o));
    // R10: at most one line at its active level
    a_r10_one_cs: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~(cs_o ^ cs_pol)));
    // R12: lines driven only while a word is in flight
    a_r12_oe_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (io_oe != 4'd0) |-> busy);
endmodule

bind sqw_engine sqw_checker #(.NUM_CS(NUM_CS)) u_chk (.*);

// File: tb/sim_sqw_engine.sv
`timescale 1ns/1ps
module sim_sqw_engine;
    logic        clk = 1'b0, rst_n = 1'b0, reg_we = 1'b0, sclk_tick = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic [3:0]  cs_pol = 4'b0010, io_in = '0, io_out, io_oe, cs_o;
    logic        sck;
    int n_chk = 0, n_bad = 0;

    always #4 clk = ~clk;

    sqw_engine u0 (.*);

    function automatic logic [31:0] mk(input int cs, input int wl_m1, input int op, input int fl_m1);
        return {2'b0, 2'(cs), 2'b0, 7'(wl_m1), 3'(op), 4'b0, 12'(fl_m1)};
    endfunction

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wreg(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic rreg(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a; #1; d = reg_rdata;
    endtask

    // Drive n beats of `step` bits of rx (nbits long) starting at beat k0; collect line 0.
    task automatic beats(input int k0, input int n, input int step, input int nbits,
                         input logic [127:0] rx, inout logic [127:0] tx);
        for (int k = k0; k < k0 + n; k++) begin
            logic [3:0] v;
            v = 4'((rx >> (nbits - step * (k + 1))) & ((128'd1 << step) - 1));
            tx = {tx[126:0], io_out[0]};
            if (step == 1) io_in = {2'b0, v[0], ~v[0]};
            else io_in = v;
            sclk_tick = 1'b1;
            @(negedge clk);
        end
        sclk_tick = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rreg(3'd1, d); chk("R1 status", d, 0);
        chk("R1 cs", cs_o, 4'b1101);
        chk("R1 oe", io_oe, 0);
        rreg(3'd4, d); chk("R1 data0", d, 0);
    endtask

    task automatic t_write8;
        logic [31:0] d; logic [127:0] tx = '0;
        wreg(3'd4, 32'h0000_00A5);
        wreg(3'd0, mk(0, 7, 2, 0));
        rreg(3'd1, d); chk("R5 R11 busy after cmd", d, 1);
        chk("R6 R10 cs0 active low", cs_o, 4'b1100);
        chk("R12 oe on write", io_oe, 4'b0001);
        beats(0, 8, 1, 8, 0, tx);
        chk("R3 write8 bits", tx[7:0], 8'hA5);
        rreg(3'd1, d); chk("R5 R11 wc after word", d, 2);
        chk("R6 cs released at frame end", cs_o, 4'b1101);
        chk("R12 oe idle", io_oe, 0);
    endtask

    task automatic t_write128;
        logic [127:0] tx = '0;
        logic [127:0] exp = 128'h01234567_89ABCDEF_F0E1D2C3_0F1E2D3C;
        wreg(3'd7, exp[127:96]); wreg(3'd6, exp[95:64]);
        wreg(3'd5, exp[63:32]);  wreg(3'd4, exp[31:0]);
        wreg(3'd0, mk(0, 127, 2, 0));
        beats(0, 128, 1, 128, 0, tx);
        chk("R3 write128 order", tx, exp);
    endtask

    task automatic t_read_lanes;
        logic [31:0] d; logic [127:0] tx = '0;
        wreg(3'd5, 32'hFFFF_FFFF);
        wreg(3'd0, mk(0, 15, 1, 0));
        chk("R12 oe off in read", io_oe, 0);
        beats(0, 16, 1, 16, 128'hBEEF, tx);
        rreg(3'd4, d); chk("R4 single read line1", d, 32'h0000_BEEF);
        rreg(3'd5, d); chk("R4 upper bits cleared", d, 0);
        wreg(3'd0, mk(0, 31, 3, 0));
        beats(0, 16, 2, 32, 128'h12345678, tx);
        rreg(3'd4, d); chk("R2 R4 dual read", d, 32'h1234_5678);
        wreg(3'd0, mk(0, 31, 7, 0));
        beats(0, 8, 4, 32, 128'hCAFEF00D, tx);
        rreg(3'd4, d); chk("R2 R4 quad read", d, 32'hCAFE_F00D);
    endtask

    task automatic t_frame;
        logic [31:0] d; logic [127:0] tx = '0;
        wreg(3'd4, 32'h11);
        wreg(3'd0, mk(1, 7, 2, 2));
        chk("R10 cs1 active high", cs_o, 4'b1111);
        beats(0, 8, 1, 8, 0, tx);
        chk("R6 cs held after word 1", cs_o, 4'b1111);
        wreg(3'd0, mk(1, 7, 2, 2));
        rreg(3'd1, d); chk("R5 wc cleared by cmd", d, 1);
        beats(0, 8, 1, 8, 0, tx);
        chk("R6 cs held after word 2", cs_o, 4'b1111);
        wreg(3'd0, mk(1, 7, 2, 2));
        beats(0, 8, 1, 8, 0, tx);
        chk("R6 cs dropped after word 3", cs_o, 4'b1101);
    endtask

    task automatic t_inval;
        logic [31:0] d; logic [127:0] tx = '0;
        wreg(3'd0, mk(2, 7, 2, 3));
        beats(0, 8, 1, 8, 0, tx);
        chk("R6 cs2 mid frame", cs_o, 4'b1001);
        wreg(3'd0, mk(0, 0, 4, 0));
        chk("R7 invalidate drops cs", cs_o, 4'b1101);
        rreg(3'd1, d); chk("R7 invalidate moves no data", d, 0);
        wreg(3'd0, mk(3, 7, 2, 0));
        chk("R7 new frame new select", cs_o, 4'b0101);
        beats(0, 8, 1, 8, 0, tx);
        chk("R7 new frame closes", cs_o, 4'b1101);
    endtask

    task automatic t_busy_ignore;
        logic [31:0] d; logic [127:0] tx = '0;
        wreg(3'd4, 32'hDEAD_BEEF);
        wreg(3'd0, mk(0, 31, 2, 0));
        beats(0, 16, 1, 32, 0, tx);
        wreg(3'd0, mk(2, 7, 4, 0));
        wreg(3'd4, 32'h0);
        rreg(3'd1, d); chk("R8 still busy", d, 1);
        chk("R8 cs unchanged", cs_o, 4'b1100);
        beats(16, 16, 1, 32, 0, tx);
        chk("R8 word intact", tx[31:0], 32'hDEAD_BEEF);
        rreg(3'd4, d); chk("R9 data write ignored", d, 32'hDEAD_BEEF);
    endtask

    task automatic summary;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write8();
        t_write128();
        t_read_lanes();
        t_frame();
        t_inval();
        t_busy_ignore();
        summary();
    end
endmodule